// File: doc/BRIEF.md
# Transaction-Sequenced CRC-16 Generator

This block produces the 16-bit check value that guards memory reads and scratchpad writes on a single-wire slave. A controller feeds it one byte at a time. With each byte it gives a kind tag (command, address or data) and a last-data marker. The block decides from the transaction type and the pass number which bytes enter the checksum. It runs the bits through a serial generator least-significant bit first, using the polynomial x^16 + x^15 + x^2 + 1. The feedback is reflected, with mask 0xA001.

On the first pass the command byte, both address bytes and the data all enter a freshly cleared generator. After a pass-start pulse the generator is cleared again, and from then on only data bytes are taken. Command and address bytes offered in such a later pass are accepted but have no effect. For a scratchpad write, the first address byte gives the starting offset inside a 32-byte scratchpad. The block follows the offset byte by byte and allows the checksum to be sent only when a byte lands on offset 31. The checksum is always shown and sent in ones-complement form, low byte first.

Top module: `crc16_txn_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `crc_inv_o` is 16'hFFFF (generator value 0), `tx_valid_o` and `send_ok_o` are 0, and `byte_ready_o` is 1.
- R2: Data bytes enter LSB first through polynomial 0x8005 in reflected form (mask 0xA001), starting from a cleared value of 0. The nine ASCII bytes "123456789" leave `crc_inv_o` = 16'h44C2. The value does not change while no byte is being shifted.
- R3: On a first pass, a command byte (kind 2'd0), two address bytes (kind 2'd1) and data bytes (kind 2'd2) are all shifted in order into the cleared generator.
- R4: `pass_start_i` clears the generator. Until the next `clr_i`, command and address bytes are accepted without changing the value, and only data bytes are shifted.
- R5: For a write transaction (`txn_wr_i` high when the first-pass command byte is accepted), the command, TA1, TA2 and data bytes are shifted in that order.
- R6: For a write, the offset is loaded from TA1 bits [4:0] and advances by one per data byte. `send_ok_o` rises after a data byte is accepted at offset 31 and stays high until `clr_i`.
- R7: A write whose last data byte does not reach offset 31 produces no `tx_valid_o` pulse.
- R8: Eight cycles after the last data byte is accepted, `tx_valid_o` is high for two consecutive cycles. The first cycle carries `~crc[7:0]` and the second carries `~crc[15:8]`. This happens for read transactions, and for writes when `send_ok_o` is high.
- R9: `clr_i` has priority over a byte offered in the same cycle. That byte is not taken, and the value returns to 16'hFFFF inverted.
- R10: `byte_ready_o` is low during the eight bit-cycles of a shifted byte and while the checksum is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clear generator and start a new transaction |
| pass_start_i | input | 1 | Clear generator and begin a later pass |
| txn_wr_i | input | 1 | Transaction is a scratchpad write (sampled with the command byte) |
| byte_valid_i | input | 1 | Byte offered |
| byte_i | input | 8 | Byte value |
| byte_kind_i | input | 2 | 0 command, 1 address, 2 data |
| last_i | input | 1 | Offered data byte is the final one |
| byte_ready_o | output | 1 | Byte accepted on this edge if valid |
| crc_inv_o | output | 16 | Current checksum, inverted |
| send_ok_o | output | 1 | Write reached scratchpad offset 31 |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_byte_o | output | 8 | Inverted checksum byte, low byte first |

## Verification
The generator is first given a standard nine-byte ASCII string. This fixes both the polynomial and the bit order, because a swapped bit order or a wrong mask gives a different, well-known value. A full first-pass read is then compared with a later pass that offers the same command and address bytes again. The difference between the two results shows whether those bytes were correctly dropped. Two writes follow, one ending at offset 31 and one stopping short, to separate gated from ungated transmission. A clear raised in the same cycle as a byte shows whether the clear wins.

// File: rtl/crc16_txn_pkg.sv
package crc16_txn_pkg;
  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_DATA = 2'd2
  } byte_kind_e;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_LO   = 2'd1,
    TX_HI   = 2'd2
  } tx_state_e;
endpackage

// File: rtl/crc16_serial_core.sv
module crc16_serial_core #(
  parameter int          CRC_W    = 16,
  parameter int          BYTE_W   = 8,
  parameter logic [15:0] POLY_REF = 16'hA001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [CRC_W-1:0]  crc_q, crc_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              fb;

  always_comb begin
    crc_n = crc_q;
    sh_n  = sh_q;
    cnt_n = cnt_q;
    fb    = crc_q[0] ^ sh_q[0];
    if (clr_i) begin
      crc_n = '0;
      cnt_n = '0;
    end else if (load_i) begin
      sh_n  = byte_i;
      cnt_n = CNT_W'(BYTE_W);
    end else if (cnt_q != '0) begin
      crc_n = (crc_q >> 1) ^ (fb ? POLY_REF[CRC_W-1:0] : '0);
      sh_n  = sh_q >> 1;
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      crc_q <= crc_n;
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1)) && !clr_i;
  assign crc_o  = crc_q;
endmodule

// File: rtl/sp_offset_tracker.sv
module sp_offset_tracker #(
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [OFS_W-1:0] start_i,
  input  logic             step_i,
  output logic             end_hit_o
);
  logic [OFS_W-1:0] ofs_q, ofs_n;
  logic             hit_q, hit_n;

  always_comb begin
    ofs_n = ofs_q;
    hit_n = hit_q;
    if (clr_i) begin
      ofs_n = '0;
      hit_n = 1'b0;
    end else if (load_i) begin
      ofs_n = start_i;
    end else if (step_i) begin
      ofs_n = ofs_q + OFS_W'(1);
      if (ofs_q == '1) hit_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      hit_q <= 1'b0;
    end else begin
      ofs_q <= ofs_n;
      hit_q <= hit_n;
    end
  end

  assign end_hit_o = hit_q;
endmodule

// File: rtl/crc16_txn_seq.sv
module crc16_txn_seq #(
  parameter int          CRC_W    = 16,
  parameter int          BYTE_W   = 8,
  parameter int          OFS_W    = 5,
  parameter logic [15:0] POLY_REF = 16'hA001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              pass_start_i,
  input  logic              txn_wr_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [1:0]        byte_kind_i,
  input  logic              last_i,
  output logic              byte_ready_o,
  output logic [CRC_W-1:0]  crc_inv_o,
  output logic              send_ok_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_byte_o
);
  import crc16_txn_pkg::*;

  localparam int HALF_W = CRC_W / 2;

  logic       first_q, first_n;
  logic       wr_q, wr_n;
  logic       ta1_q, ta1_n;
  logic       last_q, last_n;
  tx_state_e  tx_q, tx_n;

  logic accept, is_cmd, is_addr, is_data;
  logic shift_load, core_clr, core_busy, core_done;
  logic ofs_load, ofs_step;
  logic [CRC_W-1:0] crc;

  assign is_cmd  = (byte_kind_i == KIND_CMD);
  assign is_addr = (byte_kind_i == KIND_ADDR);
  assign is_data = (byte_kind_i == KIND_DATA);

  // clear and pass start outrank a byte in the same cycle
  assign accept     = byte_valid_i && byte_ready_o && !clr_i && !pass_start_i;
  assign shift_load = accept && (first_q || is_data);
  assign core_clr   = clr_i || pass_start_i;
  assign ofs_load   = accept && first_q && is_addr && wr_q && !ta1_q;
  assign ofs_step   = accept && is_data && wr_q;

  crc16_serial_core #(
    .CRC_W   (CRC_W),
    .BYTE_W  (BYTE_W),
    .POLY_REF(POLY_REF)
  ) i_core (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (core_clr),
    .load_i(shift_load),
    .byte_i(byte_i),
    .busy_o(core_busy),
    .done_o(core_done),
    .crc_o (crc)
  );

  sp_offset_tracker #(
    .OFS_W(OFS_W)
  ) i_ofs (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .load_i   (ofs_load),
    .start_i  (byte_i[OFS_W-1:0]),
    .step_i   (ofs_step),
    .end_hit_o(send_ok_o)
  );

  always_comb begin
    first_n = first_q;
    wr_n    = wr_q;
    ta1_n   = ta1_q;
    last_n  = last_q;
    tx_n    = tx_q;
    if (clr_i) begin
      first_n = 1'b1;
      wr_n    = 1'b0;
      ta1_n   = 1'b0;
      last_n  = 1'b0;
      tx_n    = TX_IDLE;
    end else if (pass_start_i) begin
      first_n = 1'b0;
      last_n  = 1'b0;
      tx_n    = TX_IDLE;
    end else begin
      if (accept && first_q && is_cmd) wr_n = txn_wr_i;
      if (ofs_load) ta1_n = 1'b1;
      if (accept && is_data && last_i) last_n = 1'b1;
      case (tx_q)
        TX_IDLE: if (core_done && last_q) begin
          last_n = 1'b0;
          if (!wr_q || send_ok_o) tx_n = TX_LO;
        end
        TX_LO:   tx_n = TX_HI;
        default: tx_n = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      wr_q    <= 1'b0;
      ta1_q   <= 1'b0;
      last_q  <= 1'b0;
      tx_q    <= TX_IDLE;
    end else begin
      first_q <= first_n;
      wr_q    <= wr_n;
      ta1_q   <= ta1_n;
      last_q  <= last_n;
      tx_q    <= tx_n;
    end
  end

  assign byte_ready_o = !core_busy && (tx_q == TX_IDLE);
  assign crc_inv_o    = ~crc;
  assign tx_valid_o   = (tx_q != TX_IDLE);
  assign tx_byte_o    = (tx_q == TX_HI) ? ~crc[CRC_W-1:HALF_W] : ~crc[HALF_W-1:0];
endmodule

// File: rtl/crc16_txn_seq_chk.sv
module crc16_txn_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_i,
  input logic        pass_start_i,
  input logic        byte_ready_o,
  input logic [15:0] crc_inv_o,
  input logic        send_ok_o,
  input logic        tx_valid_o,
  input logic        core_busy
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (crc_inv_o == 16'hFFFF) && !tx_valid_o && !send_ok_o);

  // R2
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_busy && !clr_i && !pass_start_i) |=> $stable(crc_inv_o));

  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_inv_o == 16'hFFFF) && !tx_valid_o && !send_ok_o);

  // R6
  send_ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_ok_o && !clr_i) |=> send_ok_o);

  // R8
  tx_pair_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i || pass_start_i)
    $rose(tx_valid_o) |=> tx_valid_o);

  // R8
  tx_len_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i || pass_start_i)
    (tx_valid_o && $past(tx_valid_o)) |=> !tx_valid_o);

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_busy || tx_valid_o) |-> !byte_ready_o);
endmodule

bind crc16_txn_seq crc16_txn_seq_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .pass_start_i(pass_start_i),
  .byte_ready_o(byte_ready_o),
  .crc_inv_o   (crc_inv_o),
  .send_ok_o   (send_ok_o),
  .tx_valid_o  (tx_valid_o),
  .core_busy   (core_busy)
);

// File: tb/test_crc16_txn_seq.sv
module test_crc16_txn_seq;
  logic clk, rst_n, clr_i, pass_start_i, txn_wr_i, byte_valid_i, last_i;
  logic [7:0]  byte_i;
  logic [1:0]  byte_kind_i;
  logic        byte_ready_o, send_ok_o, tx_valid_o;
  logic [15:0] crc_inv_o;
  logic [7:0]  tx_byte_o;

  int n_chk = 0;
  int n_fail = 0;
  int tx_n = 0;
  logic [7:0] tx_buf [4];
  bit done_flag = 0;

  crc16_txn_seq i_crc16_txn_seq (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .pass_start_i(pass_start_i),
    .txn_wr_i(txn_wr_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .byte_kind_i(byte_kind_i), .last_i(last_i), .byte_ready_o(byte_ready_o),
    .crc_inv_o(crc_inv_o), .send_ok_o(send_ok_o), .tx_valid_o(tx_valid_o),
    .tx_byte_o(tx_byte_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (tx_valid_o && tx_n < 4) begin
    tx_buf[tx_n] = tx_byte_o;
    tx_n = tx_n + 1;
  end

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] d, input logic lst, output logic rdy_after);
    @(negedge clk);
    byte_valid_i = 1'b1; byte_i = d; byte_kind_i = k; last_i = lst;
    while (!byte_ready_o) @(negedge clk);
    @(negedge clk);
    rdy_after = byte_ready_o;
    byte_valid_i = 1'b0; last_i = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    tx_n = 0;
  endtask

  task automatic t_reset();
    chk(crc_inv_o == 16'hFFFF, "R1 crc", crc_inv_o, 16'hFFFF);
    chk(!tx_valid_o && !send_ok_o, "R1 flags", {tx_valid_o, send_ok_o}, 0);
    chk(byte_ready_o, "R1 ready", byte_ready_o, 1);
  endtask

  task automatic t_known();
    string s = "123456789";
    logic r;
    do_clr();
    for (int i = 0; i < 9; i++) send(2'd2, s[i], 1'b0, r);
    repeat (10) @(negedge clk);
    chk(crc_inv_o == 16'h44C2, "R2 check string", crc_inv_o, 16'h44C2);
    repeat (5) @(negedge clk);
    chk(crc_inv_o == 16'h44C2, "R2 hold", crc_inv_o, 16'h44C2);
  endtask

  task automatic t_read_first();
    logic [7:0] b [6] = '{8'hA5, 8'h12, 8'h00, 8'h3C, 8'hFF, 8'h81};
    logic [15:0] e = 16'h0000;
    logic r;
    do_clr();
    txn_wr_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      send(i == 0 ? 2'd0 : (i < 3 ? 2'd1 : 2'd2), b[i], i == 5, r);
      if (i == 3) chk(!r, "R10 ready low while shifting", r, 0);
      e = crc_step(e, b[i]);
    end
    repeat (14) @(negedge clk);
    chk(crc_inv_o == ~e, "R3 first pass", crc_inv_o, ~e);
    chk(tx_n == 2, "R8 tx count", tx_n, 2);
    chk(tx_buf[0] == ~e[7:0], "R8 low byte first", tx_buf[0], ~e[7:0]);
    chk(tx_buf[1] == ~e[15:8], "R8 high byte", tx_buf[1], ~e[15:8]);
  endtask

  task automatic t_read_later();
    logic [15:0] e = 16'h0000;
    logic r;
    @(negedge clk); pass_start_i = 1'b1;
    @(negedge clk); pass_start_i = 1'b0; tx_n = 0;
    chk(crc_inv_o == 16'hFFFF, "R4 pass clears", crc_inv_o, 16'hFFFF);
    send(2'd0, 8'hA5, 1'b0, r);
    send(2'd1, 8'h12, 1'b0, r);
    chk(crc_inv_o == 16'hFFFF, "R4 cmd/addr ignored", crc_inv_o, 16'hFFFF);
    send(2'd2, 8'h55, 1'b0, r); e = crc_step(e, 8'h55);
    send(2'd2, 8'hC3, 1'b1, r); e = crc_step(e, 8'hC3);
    repeat (14) @(negedge clk);
    chk(crc_inv_o == ~e, "R4 data only", crc_inv_o, ~e);
    chk(tx_n == 2 && tx_buf[0] == ~e[7:0], "R4 later pass tx", tx_buf[0], ~e[7:0]);
  endtask

  task automatic t_write(input logic [7:0] ta1, input int nd, input bit reach);
    logic [15:0] e = 16'h0000;
    logic r;
    do_clr();
    txn_wr_i = 1'b1;
    send(2'd0, 8'h4E, 1'b0, r); e = crc_step(e, 8'h4E);
    send(2'd1, ta1, 1'b0, r);   e = crc_step(e, ta1);
    send(2'd1, 8'h00, 1'b0, r); e = crc_step(e, 8'h00);
    txn_wr_i = 1'b0;
    for (int i = 0; i < nd; i++) begin
      send(2'd2, 8'(8'h10 + i), i == nd - 1, r);
      e = crc_step(e, 8'(8'h10 + i));
    end
    repeat (14) @(negedge clk);
    chk(crc_inv_o == ~e, "R5 write sequence", crc_inv_o, ~e);
    if (reach) begin
      chk(send_ok_o, "R6 offset 31 reached", send_ok_o, 1);
      chk(tx_n == 2 && tx_buf[1] == ~e[15:8], "R8 write tx", tx_buf[1], ~e[15:8]);
    end else begin
      chk(!send_ok_o, "R6 offset 31 not reached", send_ok_o, 0);
      chk(tx_n == 0, "R7 no tx", tx_n, 0);
    end
  endtask

  task automatic t_clr_prio();
    logic r;
    send(2'd2, 8'h77, 1'b0, r);
    repeat (10) @(negedge clk);
    clr_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'h99; byte_kind_i = 2'd2;
    @(negedge clk);
    clr_i = 1'b0; byte_valid_i = 1'b0;
    chk(crc_inv_o == 16'hFFFF, "R9 clear value", crc_inv_o, 16'hFFFF);
    chk(byte_ready_o, "R9 byte not taken", byte_ready_o, 1);
    chk(!send_ok_o, "R9 flag cleared", send_ok_o, 0);
    repeat (10) @(negedge clk);
    chk(crc_inv_o == 16'hFFFF, "R9 nothing shifted", crc_inv_o, 16'hFFFF);
  endtask

  initial begin
    rst_n = 1'b0; clr_i = 1'b0; pass_start_i = 1'b0; txn_wr_i = 1'b0;
    byte_valid_i = 1'b0; byte_i = '0; byte_kind_i = '0; last_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known();
    t_read_first();
    t_read_later();
    t_write(8'h1D, 3, 1'b1);
    t_write(8'h00, 2, 1'b0);
    t_clr_prio();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule